// File: doc/BRIEF.md
# Descriptor Control-Word Coherency Guard

This block holds the control/status word of a single DMA channel's transfer descriptor. It decides what gets stored when software register writes meet the engine's start and retire events. Software writes the whole word through a plain write strobe and reads it back combinationally. The engine raises a start strobe when it begins executing the channel and a retire strobe when the major loop completes.

The channel-link enable and the scatter/gather enable are read from the stored word only when the channel retires, so software may set either one while the channel is still running. Once the done flag is set, or in the cycle it is being set, any write stores zero into both enables. Reading the word back therefore tells software whether a late request was accepted. At retirement the block raises a one-cycle link request, which carries the stored target channel, and a one-cycle scatter/gather request, each on its own pin. These request pulses are advisory strobes with no ready input. The engine side must take them in the cycle they appear, so they apply no back-pressure.

Word layout: bit 0 is the done flag, bit 1 is the link enable, bit 2 is the scatter/gather enable, bits [3+TGT_W-1:3] hold the link target, and the remaining upper bits are general descriptor fields stored as written.

Top module: `desc_csr_guard`

## Requirements
- R1: While rst_n is low, and after it rises until the first event, rd_data, link_req, link_ch and sg_req are all zero.
- R2: A write with the done flag (bit 0) clear and with no start or retire in that cycle stores wr_data unchanged. rd_data shows the new word in the cycle after the write edge.
- R3: A retire strobe without start sets the done flag (bit 0) at the next edge, whatever a simultaneous write carries in bit 0.
- R4: A start strobe clears the done flag at the next edge. It has priority over a simultaneous retire and over a simultaneous write that sets bit 0.
- R5: With no start or retire present, a write sets bit 0 to the written value, so software can clear done by writing zero.
- R6: A write that arrives while done is set stores zero in bit 1 (link enable) and bit 2 (scatter/gather enable), even if the same write clears done. All other bits take the written values.
- R7: A write in the same cycle as retire is masked as in R6. The retirement samples the enables held before that write.
- R8: In the cycle after a retire, link_req is high for exactly one cycle if bit 1 was set before the retire edge. link_ch then shows the target field sampled at that edge. At all other times link_ch is zero.
- R9: In the cycle after a retire, sg_req is high for exactly one cycle if bit 2 was set before the retire edge. This is independent of link_req: both may pulse together.
- R10: Retirement leaves bits 1 and 2 as they were stored, so an enable set before retire still reads back as set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | CSR_W | Word to write |
| rd_data | output | CSR_W | Stored control/status word |
| eng_start | input | 1 | Engine begins executing the channel |
| eng_retire | input | 1 | Engine completes the major loop |
| link_req | output | 1 | One-cycle channel-link request |
| link_ch | output | TGT_W | Target channel for the link request |
| sg_req | output | 1 | One-cycle scatter/gather request |

## Verification
The hardest case to reach is a write that lands in the very cycle of retirement. In that cycle the enables must be sampled from the old word while the written enables are dropped. Close behind it is the sequence of clearing done, writing an enable and then retiring. Directed steps place a write on the retire edge with both old and new enable values, and also run the clear-done-then-link sequence. A seeded random phase then mixes writes, starts and retires, including start and retire together, and checks every cycle against a bench model of the word.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int DONE_B = 0;
  localparam int LINK_B = 1;
  localparam int SG_B   = 2;
  localparam int TGT_LO = 3;
endpackage

// File: rtl/dcsr_wr_filter.sv
module dcsr_wr_filter #(
  parameter int CSR_W = 16
) (
  input  logic [CSR_W-1:0] wr_data,
  input  logic             done_q,
  input  logic             retire,
  output logic [CSR_W-1:0] wr_filt
);
  import dcsr_pkg::*;
  logic late;
  // a write on or after completion cannot arm a dynamic request
  always_comb begin
    late    = done_q | retire;
    wr_filt = wr_data;
    if (late) begin
      wr_filt[LINK_B] = 1'b0;
      wr_filt[SG_B]   = 1'b0;
    end
  end
endmodule

// File: rtl/dcsr_store.sv
module dcsr_store #(
  parameter int CSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_filt,
  input  logic             start,
  input  logic             retire,
  output logic [CSR_W-1:0] word_q
);
  import dcsr_pkg::*;
  logic [CSR_W-1:0] word_d;
  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wr_filt;
    if (start)       word_d[DONE_B] = 1'b0;
    else if (retire) word_d[DONE_B] = 1'b1;
  end
  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/dcsr_retire.sv
module dcsr_retire #(
  parameter int CSR_W = 16,
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic [CSR_W-1:0] word_q,
  output logic             link_req,
  output logic [TGT_W-1:0] link_ch,
  output logic             sg_req
);
  import dcsr_pkg::*;
  localparam int TGT_HI = TGT_LO + TGT_W - 1;
  logic fire_link;
  assign fire_link = retire & word_q[LINK_B];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_req <= 1'b0;
      link_ch  <= '0;
      sg_req   <= 1'b0;
    end else begin
      link_req <= fire_link;
      link_ch  <= fire_link ? word_q[TGT_HI:TGT_LO] : '0;
      sg_req   <= retire & word_q[SG_B];
    end
  end
endmodule

// File: rtl/desc_csr_guard.sv
module desc_csr_guard #(
  parameter int CSR_W = 16,
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             eng_start,
  input  logic             eng_retire,
  output logic             link_req,
  output logic [TGT_W-1:0] link_ch,
  output logic             sg_req
);
  import dcsr_pkg::*;
  logic [CSR_W-1:0] word_q;
  logic [CSR_W-1:0] wr_filt;

  dcsr_wr_filter #(.CSR_W(CSR_W)) u_filt (
    .wr_data(wr_data), .done_q(word_q[DONE_B]), .retire(eng_retire), .wr_filt(wr_filt)
  );
  dcsr_store #(.CSR_W(CSR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_filt(wr_filt),
    .start(eng_start), .retire(eng_retire), .word_q(word_q)
  );
  dcsr_retire #(.CSR_W(CSR_W), .TGT_W(TGT_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .retire(eng_retire), .word_q(word_q),
    .link_req(link_req), .link_ch(link_ch), .sg_req(sg_req)
  );
  assign rd_data = word_q;
endmodule

// File: rtl/dcsr_guard_chk.sv
module dcsr_guard_chk #(
  parameter int CSR_W = 16,
  parameter int TGT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CSR_W-1:0] wr_data,
  input logic [CSR_W-1:0] rd_data,
  input logic             eng_start,
  input logic             eng_retire,
  input logic             link_req,
  input logic [TGT_W-1:0] link_ch,
  input logic             sg_req
);
  localparam int TGT_HI = 3 + TGT_W - 1;
  AST_DONE_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_retire && !eng_start |=> rd_data[0]); // R3
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !rd_data[0]); // R4
  AST_LATE_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (rd_data[0] || eng_retire) |=> rd_data[2:1] == 2'b00); // R6
  AST_LINK_FROM_OLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_retire |=> link_req == $past(rd_data[1])); // R7
  AST_LINK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_retire && rd_data[1] |=> link_ch == $past(rd_data[TGT_HI:3])); // R8
  AST_NO_LINK_WITHOUT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_retire |=> !link_req && link_ch == '0); // R8
  AST_SG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_retire |=> sg_req == $past(rd_data[2])); // R9
  AST_NO_SG_WITHOUT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_retire |=> !sg_req); // R9
  AST_RETIRE_KEEPS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    eng_retire && !wr_en |=> rd_data[2:1] == $past(rd_data[2:1])); // R10
endmodule

bind desc_csr_guard dcsr_guard_chk #(.CSR_W(CSR_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/sim_desc_csr_guard.sv
module sim_desc_csr_guard;
  localparam int CSR_W = 16;
  localparam int TGT_W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int TGT_HI = 3 + TGT_W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CSR_W-1:0] wr_data = '0;
  logic eng_start = 1'b0;
  logic eng_retire = 1'b0;
  logic [CSR_W-1:0] rd_data;
  logic link_req, sg_req;
  logic [TGT_W-1:0] link_ch;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [CSR_W-1:0] exp_w = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_csr_guard #(.CSR_W(CSR_W), .TGT_W(TGT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eng_start(eng_start), .eng_retire(eng_retire),
    .link_req(link_req), .link_ch(link_ch), .sg_req(sg_req)
  );

  function automatic logic [CSR_W-1:0] next_word(logic [CSR_W-1:0] w, logic we,
      logic [CSR_W-1:0] d, logic st, logic rt);
    logic [CSR_W-1:0] n;
    n = w;
    if (we) begin
      n = d;
      if (w[0] || rt) n[2:1] = 2'b00;  // R6 R7
    end
    if (st) n[0] = 1'b0;                // R4
    else if (rt) n[0] = 1'b1;           // R3
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [CSR_W-1:0] d, input logic st,
      input logic rt, input string req);
    logic e_l, e_s;
    logic [TGT_W-1:0] e_ch;
    wr_en = we; wr_data = d; eng_start = st; eng_retire = rt;
    e_l  = rt & exp_w[1];
    e_s  = rt & exp_w[2];
    e_ch = e_l ? exp_w[TGT_HI:3] : '0;
    exp_w = next_word(exp_w, we, d, st, rt);
    @(negedge clk);
    chk({req, " word"}, 32'(rd_data), 32'(exp_w));
    chk({req, " R8 link_req"}, 32'(link_req), 32'(e_l));
    chk({req, " R8 link_ch"}, 32'(link_ch), 32'(e_ch));
    chk({req, " R9 sg_req"}, 32'(sg_req), 32'(e_s));
    wr_en = 1'b0; eng_start = 1'b0; eng_retire = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, with an attempted write held during reset
    wr_en = 1'b1; wr_data = 16'hFFFF; eng_retire = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", 32'(rd_data), 0);
    chk("R1 link_req in reset", 32'(link_req), 0);
    chk("R1 sg_req in reset", 32'(sg_req), 0);
    wr_en = 1'b0; eng_retire = 1'b0; rst_n = 1'b1;
    step(0, '0, 0, 0, "R1 idle");
    // R2: plain write while running
    step(1, 16'hA5F0 | 16'h0006 | (16'(5) << 3), 0, 0, "R2 store");
    // R10 R8 R9: retire fires both, enables kept
    step(0, '0, 0, 1, "R8 R9 R10 retire");
    chk("R10 link kept", 32'(rd_data[1]), 1);
    // R6: late write with done set, tries to clear done and re-arm
    step(1, 16'h3C0E, 0, 0, "R6 masked");
    chk("R6 enables zero", 32'(rd_data[2:1]), 0);
    // R5: software clears done, then arms link
    step(1, 16'h0000, 0, 0, "R5 clear done");
    chk("R5 done clear", 32'(rd_data[0]), 0);
    step(1, 16'h0002 | (16'(9) << 3), 0, 0, "R2 dynamic link");
    // R7: write at retire edge, old link sampled, new sg masked
    step(1, 16'h0004, 0, 1, "R7 same cycle");
    chk("R7 enables masked", 32'(rd_data[2:1]), 0);
    // R4: start beats write setting done, and beats retire
    step(1, 16'h0001, 1, 0, "R4 start vs write");
    chk("R4 done clear", 32'(rd_data[0]), 0);
    step(0, '0, 0, 1, "R3 retire");
    step(0, '0, 1, 1, "R4 start vs retire");
    chk("R4 done clear vs retire", 32'(rd_data[0]), 0);
    step(1, 16'h0007, 0, 0, "R5 set done by write");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic we, st, rt;
      we = ($urandom % 2) == 0;
      st = ($urandom % 8) == 0;
      rt = ($urandom % 6) == 0;
      step(we, 16'($urandom), st, rt, "R2-random");
    end
    finish_run();
  end
endmodule